// File: doc/BRIEF.md
# 8-bit Accumulator Arithmetic Unit with Status Word

This block performs the five arithmetic operations of an 8051-style core (add, add with carry, subtract with borrow, multiply, divide) on the current accumulator value and a second operand. It also owns the program status word that records the results. The surrounding core supplies the accumulator value and an operation strobe. The block returns the new accumulator and B values, each with a write enable, in the same cycle, and it updates the status flags on the clock edge. The parity bit is not stored. It is derived at all times from the accumulator value presented on `acc_q`.

The status word is also a special-function register. Software can write it as a whole byte or one bit at a time, and its current value is always on `psw_rdata`. The two bank-select bits in the status word form the top of a working-register address. The core uses this address to reach one of four eight-entry register banks.

Top module: `acc_arith_unit`

## Requirements
- R1: The status word bit order is CY=7, AC=6, F0=5, RS1=4, RS0=3, OV=2, F1=1, PARITY=0. The register answers at SFR address 0xD0 and holds 0x00 after reset, apart from the live parity bit.
- R2: With `op_valid` high, `op_code` 0 selects ADD and 1 selects ADDC. The accumulator result is acc+opnd, plus CY only for ADDC. CY is set on carry out of bit 7, AC on carry out of bit 3, and OV on a two's-complement overflow.
- R3: `op_code` 2 selects SUBB, which yields acc−opnd−CY. CY is set when the full subtraction borrows, AC when the low nibble borrows, and OV on a signed overflow.
- R4: `op_code` 3 selects MUL. The low byte of acc×opnd goes to the accumulator and the high byte to B. OV is set exactly when the product exceeds 255, and CY and AC are cleared.
- R5: `op_code` 4 with a nonzero operand selects DIV. The quotient goes to the accumulator and the remainder to B, and OV, CY and AC are cleared.
- R6: DIV by zero asserts neither `acc_we` nor `b_we`. It sets OV and clears CY and AC.
- R7: PARITY reads 1 when `acc_q` has an odd number of ones and 0 otherwise, following `acc_q` in the same cycle.
- R8: A byte write (`sfr_we`) or a single-bit write (`sfr_bit_we`, bit index as in R1) to address 0xD0 changes the status word on the next edge. Writes to other addresses, and writes aimed at PARITY, have no effect.
- R9: Arithmetic never changes F0, F1, RS1 or RS0. `op_code` values 5 to 7 change nothing and assert no write enable.
- R10: `reg_addr` equals {RS1, RS0, `reg_idx`}. A bank change written in one cycle appears on `reg_addr` only from the next cycle.
- R11: When an SFR write and an arithmetic operation fall in the same cycle, CY, AC and OV take the arithmetic values, while F0, F1 and the bank bits take the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Execute `op_code` this cycle |
| op_code | input | 3 | Operation select (0 ADD, 1 ADDC, 2 SUBB, 3 MUL, 4 DIV) |
| acc_q | input | DATA_W | Current accumulator value |
| opnd | input | DATA_W | Second operand (B for MUL and DIV) |
| acc_nxt | output | DATA_W | New accumulator value |
| acc_we | output | 1 | Accumulator write enable |
| b_nxt | output | DATA_W | New B value (high product byte or remainder) |
| b_we | output | 1 | B write enable |
| sfr_addr | input | 8 | SFR address for writes |
| sfr_we | input | 1 | Byte write strobe |
| sfr_wdata | input | 7 | Byte write data for bits 7..1 |
| sfr_bit_we | input | 1 | Single-bit write strobe |
| sfr_bit_idx | input | 3 | Bit position for a single-bit write |
| sfr_bit_val | input | 1 | Value for a single-bit write |
| psw_rdata | output | 8 | Status word read value |
| reg_idx | input | REG_IDX_W | Working register number within the bank |
| reg_addr | output | REG_IDX_W+2 | Working register address inside internal RAM |

## Verification
The bench builds the block with its defaults: DATA_W=8, REG_IDX_W=3, SFR address 0xD0 and the unrolled restoring divider. With these settings every 8-bit operand pair can be reached, including the all-ones product, divide-by-zero and the signed boundaries at 0x7F and 0x80, and every divider result can be compared against integer arithmetic. The 3-bit register index makes all 32 bank addresses observable. Random operations are mixed with stray, matching and bit-level SFR writes, so CY is chained between ADDC and SUBB under changing carry-in.

// File: rtl/aau_pkg.sv
package aau_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_ADDC = 3'd1,
      OP_SUBB = 3'd2,
      OP_MUL  = 3'd3,
      OP_DIV  = 3'd4
   } aau_op_e;

   localparam int PSW_W   = 8;
   localparam int PSW_CY  = 7;
   localparam int PSW_AC  = 6;
   localparam int PSW_F0  = 5;
   localparam int PSW_RS1 = 4;
   localparam int PSW_RS0 = 3;
   localparam int PSW_OV  = 2;
   localparam int PSW_F1  = 1;
   localparam int PSW_P   = 0;

   typedef struct packed {
      logic upd;
      logic cy;
      logic ac;
      logic ov;
   } flag_upd_t;

endpackage

// File: rtl/aau_addsub.sv
module aau_addsub #(
   parameter int DATA_W = 8,
   localparam int NIB_W = DATA_W / 2,
   localparam int MSB   = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cy_o,
   output logic              ac_o,
   output logic              ov_o
);

   logic [DATA_W:0] full_w;
   logic [NIB_W:0]  low_w;

   always_comb begin
      if (sub_i) begin
         full_w = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_i};
         low_w  = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]}
                  - {{NIB_W{1'b0}}, cin_i};
      end else begin
         full_w = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
         low_w  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]}
                  + {{NIB_W{1'b0}}, cin_i};
      end
      res_o = full_w[DATA_W-1:0];
      // the extra top bit is carry for add and borrow for subtract
      cy_o  = full_w[DATA_W];
      ac_o  = low_w[NIB_W];
      if (sub_i)
         ov_o = (a_i[MSB] != b_i[MSB]) && (full_w[MSB] != a_i[MSB]);
      else
         ov_o = (a_i[MSB] == b_i[MSB]) && (full_w[MSB] != a_i[MSB]);
   end

   logic [DATA_W-1:0] undo_w;
   assign undo_w = res_o + b_i + {{(DATA_W-1){1'b0}}, cin_i};

   AST_SUB_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
      sub_i |-> (undo_w == a_i)); // R3

endmodule

// File: rtl/aau_muldiv.sv
module aau_muldiv #(
   parameter int DATA_W       = 8,
   parameter bit DIV_UNROLLED = 1'b1,
   localparam int PROD_W      = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              is_div_i,
   output logic [DATA_W-1:0] lo_o,
   output logic [DATA_W-1:0] hi_o,
   output logic              ov_o,
   output logic              div_zero_o
);

   logic [PROD_W-1:0] prod_w;
   logic [DATA_W-1:0] quo_w;
   logic [DATA_W-1:0] rem_w;

   assign prod_w     = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};
   assign div_zero_o = (b_i == '0);

   generate
      if (DIV_UNROLLED) begin : g_div_restoring
         logic [DATA_W:0]   trial_w;
         logic [DATA_W-1:0] part_w;
         always_comb begin
            part_w = '0;
            quo_w  = '0;
            trial_w = '0;
            for (int i = DATA_W - 1; i >= 0; i--) begin
               trial_w = {part_w, a_i[i]};
               if (trial_w >= {1'b0, b_i}) begin
                  trial_w  = trial_w - {1'b0, b_i};
                  quo_w[i] = 1'b1;
               end
               part_w = trial_w[DATA_W-1:0];
            end
            rem_w = part_w;
         end
      end else begin : g_div_operator
         assign quo_w = div_zero_o ? '0  : a_i / b_i;
         assign rem_w = div_zero_o ? a_i : a_i % b_i;
      end
   endgenerate

   always_comb begin
      if (is_div_i) begin
         lo_o = quo_w;
         hi_o = rem_w;
         ov_o = div_zero_o;
      end else begin
         lo_o = prod_w[DATA_W-1:0];
         hi_o = prod_w[PROD_W-1:DATA_W];
         ov_o = |prod_w[PROD_W-1:DATA_W];
      end
   end

   logic [PROD_W-1:0] recomb_w;
   assign recomb_w = {{DATA_W{1'b0}}, lo_o} * {{DATA_W{1'b0}}, b_i}
                   + {{DATA_W{1'b0}}, hi_o};

   AST_DIV_RECOMBINE: assert property (@(posedge clk) disable iff (!rst_n)
      (is_div_i && !div_zero_o) |-> (recomb_w == {{DATA_W{1'b0}}, a_i}) && (hi_o < b_i)); // R5

   AST_MUL_OV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !is_div_i |-> (ov_o == ({hi_o, lo_o} > {{DATA_W{1'b0}}, {DATA_W{1'b1}}}))); // R4

endmodule

// File: rtl/aau_status.sv
module aau_status
   import aau_pkg::*;
#(
   parameter int         DATA_W    = 8,
   parameter int         REG_IDX_W = 3,
   parameter logic [7:0] SFR_ADDR  = 8'hD0,
   localparam int        RADDR_W   = REG_IDX_W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [7:0]           sfr_addr,
   input  logic                 sfr_we,
   input  logic [PSW_W-1:1]     sfr_wdata,
   input  logic                 sfr_bit_we,
   input  logic [2:0]           sfr_bit_idx,
   input  logic                 sfr_bit_val,
   input  logic [DATA_W-1:0]    acc_q,
   input  flag_upd_t            flag_upd,
   input  logic [REG_IDX_W-1:0] reg_idx,
   output logic [PSW_W-1:0]     psw_rdata,
   output logic                 cy_q,
   output logic [RADDR_W-1:0]   reg_addr
);

   logic [PSW_W-1:1] psw_q;
   logic [PSW_W-1:1] psw_d;
   logic             sfr_hit;
   logic             sfr_any;

   assign sfr_hit = (sfr_addr == SFR_ADDR);
   assign sfr_any = sfr_hit && (sfr_we || sfr_bit_we);

   always_comb begin
      psw_d = psw_q;
      if (sfr_hit && sfr_we)
         psw_d = sfr_wdata;
      // bit 0 is the live parity and cannot be written
      if (sfr_hit && sfr_bit_we && (sfr_bit_idx != 3'd0))
         psw_d[sfr_bit_idx] = sfr_bit_val;
      // arithmetic results override software for the result flags
      if (flag_upd.upd) begin
         psw_d[PSW_CY] = flag_upd.cy;
         psw_d[PSW_AC] = flag_upd.ac;
         psw_d[PSW_OV] = flag_upd.ov;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) psw_q <= '0;
      else        psw_q <= psw_d;
   end

   assign psw_rdata = {psw_q, ^acc_q};
   assign cy_q      = psw_q[PSW_CY];
   assign reg_addr  = {psw_q[PSW_RS1], psw_q[PSW_RS0], reg_idx};

   logic [3:0] user_bits;
   assign user_bits = {psw_q[PSW_F0], psw_q[PSW_RS1], psw_q[PSW_RS0], psw_q[PSW_F1]};

   AST_USER_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !sfr_any |=> $stable(user_bits)); // R9

   AST_ARITH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_upd.upd && sfr_any) |=> (psw_q[PSW_CY] == $past(flag_upd.cy))
                                 && (psw_q[PSW_AC] == $past(flag_upd.ac))
                                 && (psw_q[PSW_OV] == $past(flag_upd.ov))); // R11

   AST_BANK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_hit && sfr_we && !sfr_bit_we)
         |=> (reg_addr[RADDR_W-1 -: 2] == $past(sfr_wdata[PSW_RS1:PSW_RS0]))); // R10

endmodule

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
   import aau_pkg::*;
#(
   parameter int         DATA_W       = 8,
   parameter int         REG_IDX_W    = 3,
   parameter logic [7:0] SFR_ADDR     = 8'hD0,
   parameter bit         DIV_UNROLLED = 1'b1,
   localparam int        RADDR_W      = REG_IDX_W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic [2:0]           op_code,
   input  logic [DATA_W-1:0]    acc_q,
   input  logic [DATA_W-1:0]    opnd,
   output logic [DATA_W-1:0]    acc_nxt,
   output logic                 acc_we,
   output logic [DATA_W-1:0]    b_nxt,
   output logic                 b_we,
   input  logic [7:0]           sfr_addr,
   input  logic                 sfr_we,
   input  logic [PSW_W-1:1]     sfr_wdata,
   input  logic                 sfr_bit_we,
   input  logic [2:0]           sfr_bit_idx,
   input  logic                 sfr_bit_val,
   output logic [PSW_W-1:0]     psw_rdata,
   input  logic [REG_IDX_W-1:0] reg_idx,
   output logic [RADDR_W-1:0]   reg_addr
);

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("acc_arith_unit: DATA_W must be even and at least 4");
      end
      if (REG_IDX_W < 1) begin : g_bad_idx
         $error("acc_arith_unit: REG_IDX_W must be at least 1");
      end
   endgenerate

   logic is_add, is_addc, is_subb, is_mul, is_div, is_as;
   assign is_add  = op_valid && (op_code == OP_ADD);
   assign is_addc = op_valid && (op_code == OP_ADDC);
   assign is_subb = op_valid && (op_code == OP_SUBB);
   assign is_mul  = op_valid && (op_code == OP_MUL);
   assign is_div  = op_valid && (op_code == OP_DIV);
   assign is_as   = is_add || is_addc || is_subb;

   logic              cy_q;
   logic              as_cin;
   logic [DATA_W-1:0] as_res;
   logic              as_cy, as_ac, as_ov;
   logic [DATA_W-1:0] md_lo, md_hi;
   logic              md_ov, md_zero;
   flag_upd_t         upd_s;

   assign as_cin = (is_addc || is_subb) ? cy_q : 1'b0;

   aau_addsub #(.DATA_W(DATA_W)) u_addsub (
      .clk   (clk),
      .rst_n (rst_n),
      .a_i   (acc_q),
      .b_i   (opnd),
      .cin_i (as_cin),
      .sub_i (is_subb),
      .res_o (as_res),
      .cy_o  (as_cy),
      .ac_o  (as_ac),
      .ov_o  (as_ov)
   );

   aau_muldiv #(.DATA_W(DATA_W), .DIV_UNROLLED(DIV_UNROLLED)) u_muldiv (
      .clk        (clk),
      .rst_n      (rst_n),
      .a_i        (acc_q),
      .b_i        (opnd),
      .is_div_i   (is_div),
      .lo_o       (md_lo),
      .hi_o       (md_hi),
      .ov_o       (md_ov),
      .div_zero_o (md_zero)
   );

   always_comb begin
      acc_nxt = is_as ? as_res : ((is_mul || is_div) ? md_lo : acc_q);
      b_nxt   = md_hi;
      acc_we  = is_as || is_mul || (is_div && !md_zero);
      b_we    = is_mul || (is_div && !md_zero);
      upd_s.upd = is_as || is_mul || is_div;
      upd_s.cy  = is_as && as_cy;
      upd_s.ac  = is_as && as_ac;
      upd_s.ov  = is_as ? as_ov : md_ov;
   end

   aau_status #(
      .DATA_W    (DATA_W),
      .REG_IDX_W (REG_IDX_W),
      .SFR_ADDR  (SFR_ADDR)
   ) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .sfr_addr    (sfr_addr),
      .sfr_we      (sfr_we),
      .sfr_wdata   (sfr_wdata),
      .sfr_bit_we  (sfr_bit_we),
      .sfr_bit_idx (sfr_bit_idx),
      .sfr_bit_val (sfr_bit_val),
      .acc_q       (acc_q),
      .flag_upd    (upd_s),
      .reg_idx     (reg_idx),
      .psw_rdata   (psw_rdata),
      .cy_q        (cy_q),
      .reg_addr    (reg_addr)
   );

   AST_CARRY_CLEAR_MULDIV: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mul || is_div) |=> !psw_rdata[PSW_CY]); // R4

   AST_DIV_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (is_div && (opnd == '0)) |=> psw_rdata[PSW_OV]); // R6

endmodule

// File: tb/acc_arith_unit_bench.sv
module acc_arith_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PSW_ADR    = 8'hD0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [2:0] op_code = '0;
   logic [7:0] acc_q = '0;
   logic [7:0] opnd = '0;
   logic [7:0] acc_nxt, b_nxt;
   logic       acc_we, b_we;
   logic [7:0] sfr_addr = '0;
   logic       sfr_we = 1'b0;
   logic [7:1] sfr_wdata = '0;
   logic       sfr_bit_we = 1'b0;
   logic [2:0] sfr_bit_idx = '0;
   logic       sfr_bit_val = 1'b0;
   logic [7:0] psw_rdata;
   logic [2:0] reg_idx = '0;
   logic [4:0] reg_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_arith_unit u_acc_arith_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .acc_q(acc_q), .opnd(opnd), .acc_nxt(acc_nxt), .acc_we(acc_we),
      .b_nxt(b_nxt), .b_we(b_we), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
      .sfr_wdata(sfr_wdata), .sfr_bit_we(sfr_bit_we), .sfr_bit_idx(sfr_bit_idx),
      .sfr_bit_val(sfr_bit_val), .psw_rdata(psw_rdata), .reg_idx(reg_idx),
      .reg_addr(reg_addr)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // bench model of the stored status bits
   bit m_cy, m_ac, m_f0, m_ov, m_f1;
   int m_rs;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic int ones_odd(input int v);
      int c = 0;
      for (int i = 0; i < 8; i++) c += (v >> i) & 1;
      return c & 1;
   endfunction

   function automatic int model_psw(input int acc);
      return (int'(m_cy) << 7) | (int'(m_ac) << 6) | (int'(m_f0) << 5) | (m_rs << 3)
           | (int'(m_ov) << 2) | (int'(m_f1) << 1) | ones_odd(acc);
   endfunction

   function automatic int sgn(input int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   // one cycle of stimulus: optional operation plus optional byte write
   task automatic step(input bit opv, input int code, input int a, input int b,
                       input bit wv, input int wadr, input int wdat, input string tag);
      int  e_acc, e_b, s, cin, ss;
      bit  e_awe, e_bwe, fl, n_cy, n_ac, n_ov;
      e_acc = a; e_b = 0; e_awe = 0; e_bwe = 0; fl = 0;
      n_cy = 0; n_ac = 0; n_ov = 0;
      @(negedge clk);
      op_valid = opv; op_code = code[2:0]; acc_q = a[7:0]; opnd = b[7:0];
      sfr_we = wv; sfr_addr = wadr[7:0]; sfr_wdata = wdat[7:1];
      if (opv) begin
         case (code)
            0, 1: begin
               cin = (code == 1) ? int'(m_cy) : 0;
               s = a + b + cin; ss = sgn(a) + sgn(b) + cin;
               e_acc = s & 255; e_awe = 1; fl = 1;
               n_cy = (s > 255); n_ac = (((a & 15) + (b & 15) + cin) > 15);
               n_ov = (ss > 127) || (ss < -128);
            end
            2: begin
               cin = int'(m_cy);
               s = a - b - cin; ss = sgn(a) - sgn(b) - cin;
               e_acc = s & 255; e_awe = 1; fl = 1;
               n_cy = (s < 0); n_ac = (((a & 15) - (b & 15) - cin) < 0);
               n_ov = (ss > 127) || (ss < -128);
            end
            3: begin
               s = a * b; e_acc = s & 255; e_b = s >> 8;
               e_awe = 1; e_bwe = 1; fl = 1; n_ov = (s > 255);
            end
            4: begin
               fl = 1;
               if (b == 0) n_ov = 1;
               else begin
                  e_acc = a / b; e_b = a % b; e_awe = 1; e_bwe = 1;
               end
            end
            default: ;
         endcase
      end
      #1;
      chk({tag, " acc_we"}, int'(acc_we), int'(e_awe));
      if (e_awe) chk({tag, " acc_nxt"}, int'(acc_nxt), e_acc);
      chk({tag, " b_we"}, int'(b_we), int'(e_bwe));
      if (e_bwe) chk({tag, " b_nxt"}, int'(b_nxt), e_b);
      @(negedge clk);
      op_valid = 0; sfr_we = 0;
      if (wv && wadr == PSW_ADR) begin
         m_cy = wdat[7]; m_ac = wdat[6]; m_f0 = wdat[5]; m_rs = (wdat >> 3) & 3;
         m_ov = wdat[2]; m_f1 = wdat[1];
      end
      if (fl) begin m_cy = n_cy; m_ac = n_ac; m_ov = n_ov; end
      #1;
      chk({tag, " psw"}, int'(psw_rdata), model_psw(a));
   endtask

   task automatic bitw(input int adr, input int idx, input bit val, input string tag);
      @(negedge clk);
      sfr_bit_we = 1; sfr_addr = adr[7:0]; sfr_bit_idx = idx[2:0]; sfr_bit_val = val;
      @(negedge clk);
      sfr_bit_we = 0;
      if (adr == PSW_ADR) begin
         case (idx)
            7: m_cy = val; 6: m_ac = val; 5: m_f0 = val;
            4: m_rs = (m_rs & 1) | (int'(val) << 1);
            3: m_rs = (m_rs & 2) | int'(val);
            2: m_ov = val; 1: m_f1 = val;
            default: ;
         endcase
      end
      #1;
      chk({tag, " psw"}, int'(psw_rdata), model_psw(int'(acc_q)));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed = 32'h5eed;
      void'($urandom(seed));
      reg_idx = 3'd5;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 psw in reset", int'(psw_rdata), 0);
      rst_n = 1;
      #1;
      chk("R1 psw after reset", int'(psw_rdata), 0);
      chk("R10 reg_addr after reset", int'(reg_addr), 5);

      // R2 directed
      step(1, 0, 8'hFF, 8'h01, 0, 0, 0, "R2 add wrap");
      step(1, 0, 8'h7F, 8'h01, 0, 0, 0, "R2 add ov");
      step(1, 1, 8'h0F, 8'h00, 0, 0, 0, "R2 addc cy0");
      step(1, 0, 8'h80, 8'h80, 0, 0, 0, "R2 add neg ov");
      step(1, 1, 8'h0F, 8'h00, 0, 0, 0, "R2 addc cy1");
      step(1, 0, 8'h0F, 8'h00, 0, 0, 0, "R2 add ignores cy");
      // R3 directed
      step(1, 2, 8'h00, 8'h01, 0, 0, 0, "R3 subb borrow");
      step(1, 2, 8'h80, 8'h00, 0, 0, 0, "R3 subb ov with cy");
      step(1, 2, 8'h10, 8'h01, 0, 0, 0, "R3 subb nibble");
      // R4 / R5 / R6
      step(1, 3, 8'hFF, 8'hFF, 0, 0, 0, "R4 mul max");
      step(1, 3, 8'd10, 8'd20, 0, 0, 0, "R4 mul small");
      step(1, 4, 8'd250, 8'd7, 0, 0, 0, "R5 div");
      step(1, 4, 8'd3, 8'd9, 0, 0, 0, "R5 div small");
      step(1, 4, 8'hA5, 8'h00, 0, 0, 0, "R6 div zero");
      // R9 undefined codes
      step(1, 5, 8'h12, 8'h34, 0, 0, 0, "R9 code5");
      step(1, 7, 8'hFF, 8'hFF, 0, 0, 0, "R9 code7");
      // R8 writes
      step(0, 0, 8'h00, 0, 1, PSW_ADR, 8'hFF, "R8 byte write parity ignored");
      step(0, 0, 8'h01, 0, 1, 8'hE0, 8'h00, "R8 other address");
      step(0, 0, 8'h00, 0, 1, PSW_ADR, 8'h00, "R8 byte clear");
      bitw(PSW_ADR, 5, 1, "R8 bit F0");
      bitw(PSW_ADR, 0, 1, "R8 bit parity ignored");
      bitw(8'hD1, 1, 1, "R8 bit other address");
      bitw(PSW_ADR, 1, 1, "R8 bit F1");
      // R9 arithmetic keeps user bits
      step(1, 0, 8'hFF, 8'hFF, 0, 0, 0, "R9 add keeps F0 F1");
      // R7 parity follows acc
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         acc_q = 8'($urandom);
         #1;
         chk("R7 parity", int'(psw_rdata[0]), ones_odd(int'(acc_q)));
      end
      // R10 bank timing
      @(negedge clk);
      sfr_we = 1; sfr_addr = 8'hD0; sfr_wdata = 7'(8'h18 >> 1); reg_idx = 3'd2;
      #1;
      chk("R10 old bank same cycle", int'(reg_addr), (m_rs << 3) | 2);
      @(negedge clk);
      sfr_we = 0; m_cy = 0; m_ac = 0; m_f0 = 0; m_rs = 3; m_ov = 0; m_f1 = 0;
      #1;
      chk("R10 new bank", int'(reg_addr), 8'h1A);
      for (int r = 0; r < 4; r++) begin
         step(0, 0, 0, 0, 1, PSW_ADR, r << 3, "R10 bank write");
         reg_idx = 3'd7;
         #1;
         chk("R10 bank addr", int'(reg_addr), (r << 3) | 7);
      end
      // R11 same cycle
      step(1, 0, 8'hFF, 8'h01, 1, PSW_ADR, 8'h22, "R11 add vs write");
      step(1, 3, 8'h02, 8'h03, 1, PSW_ADR, 8'hC6, "R11 mul vs write");
      // random mix
      for (int n = 0; n < 600; n++) begin
         int code, a, b, wad, wd;
         bit wv;
         code = $urandom % 8;
         a = $urandom % 256;
         b = (($urandom % 8) == 0) ? 0 : $urandom % 256;
         wv = (($urandom % 4) == 0);
         wad = (($urandom % 2) == 0) ? PSW_ADR : $urandom % 256;
         wd = $urandom % 256;
         step(($urandom % 8) != 0, code, a, b, wv, wad, wd, "R2 R3 R4 R5 R6 R11 random");
         if (($urandom % 10) == 0)
            bitw((($urandom % 4) == 0) ? 8'h55 : PSW_ADR, $urandom % 8, 1'($urandom), "R8 random bit");
      end
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule